// File: doc/BRIEF.md
# Low-Power Pseudo-Random Pattern Source

This block feeds stimulus to a circuit under test during logic self-test. Its core is a maximal-length Fibonacci shift register. A plain register of this kind changes many input bits at every step, so the block spreads each step over two clock cycles. In the first cycle only the lower half of the register takes its new value. In the second cycle the upper half follows. Between every pair of full register states there is therefore one extra intermediate vector, and each applied vector differs from the one before it in fewer bits.

The register bits then pass through a row of two-input multiplexers before they reach the outputs. All of the multiplexers share one select line, the most significant state bit. When that bit is set, neighbouring output bits swap places. A strobe marks every cycle in which a new vector is presented. A synchronous load sets the starting state, and a zero seed is replaced so that the register cannot lock up.

Top module: `lowpwr_tpg`

## Requirements
- R1: While reset is low and directly after it, the register holds RST_SEED (default 1), `pattern_o` shows that state through the swap network (binary 001 at width 3), and `valid_o` is 0.
- R2: On a first half-step (`en_i`=1, `load_i`=0, phase 0), only the lower WIDTH/2 state bits take the lower bits of the next register state. The upper bits keep their value, and the phase becomes 1.
- R3: On a second half-step (phase 1), the upper bits take the upper bits of the next state that was computed from the state before the first half-step. The lower bits are unchanged. After both half-steps the state equals one Fibonacci step: next = {s[W-2:0], XOR of the tapped bits}. At width 3 the taps are bits 2 and 1.
- R4: The full states (those seen at phase 0) are never zero. They repeat with a period of exactly 2^WIDTH−1 full steps, in the order the Fibonacci model gives.
- R5: `valid_o` is 1 in the cycle after every half-step edge, and 0 after any edge with `en_i`=0 or `load_i`=1.
- R6: With `en_i`=0 and `load_i`=0, the state, the phase and `pattern_o` hold.
- R7: `load_i` is synchronous and takes priority over `en_i`. It loads `seed_i` and returns the phase to 0.
- R8: Loading an all-zero seed sets the state to 1 instead.
- R9: Output bit WIDTH−1 always equals state bit WIDTH−1. When that bit is 1, output bits (0,1), (2,3), and so on below it are swapped pairwise, and a leftover unpaired bit passes straight through. When it is 0, all bits pass straight through.
- R10: Over one full period of 2(2^WIDTH−1) applied vectors, the summed Hamming distance between consecutive vectors is below twice the summed distance of the plain register over its period. The average change per applied vector is therefore lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance one half-step per cycle |
| load_i | input | 1 | Synchronous seed load |
| seed_i | input | WIDTH | Seed value |
| pattern_o | output | WIDTH | Test vector after bit interchange |
| valid_o | output | 1 | New vector presented this cycle |

## Verification
The bound checker tests these rules on every clock edge:
- Each half-step touches only its own half of the register.
- The strobe follows the enable and the load.
- The outputs hold while the block is idle.
- A load clears the phase, and a zero seed becomes 1.
- The select bit reaches the output unchanged.
- No full state is zero.

Some properties need a whole sequence of vectors, so only the bench scenarios can show them:
- the exact vector order against a reference model,
- the period length of 2^WIDTH−1,
- the reduction in Hamming distance across a period.

// File: rtl/lptpg_pkg.sv
package lptpg_pkg;

   localparam int unsigned MAX_WIDTH = 16;

   // Maximal-length feedback masks for a left-shifting Fibonacci register
   function automatic logic [MAX_WIDTH-1:0] tap_mask(input int unsigned w);
      logic [MAX_WIDTH-1:0] m;
      m = '0;
      case (w)
         2:  m = 16'h0003;
         3:  m = 16'h0006;
         4:  m = 16'h000C;
         5:  m = 16'h0014;
         6:  m = 16'h0030;
         7:  m = 16'h0060;
         8:  m = 16'h00B8;
         9:  m = 16'h0110;
         10: m = 16'h0240;
         11: m = 16'h0500;
         12: m = 16'h0829;
         13: m = 16'h100D;
         14: m = 16'h2015;
         15: m = 16'h6000;
         16: m = 16'hD008;
         default: m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/lptpg_phase.sv
module lptpg_phase (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic load_i,
   output logic phase_o,
   output logic step_a_o,
   output logic step_b_o,
   output logic valid_o
);

   logic phase_q;
   logic valid_q;
   logic advance;

   assign advance  = en_i & ~load_i;
   assign step_a_o = advance & ~phase_q;
   assign step_b_o = advance & phase_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= advance;
         if (load_i)
            phase_q <= 1'b0;
         else if (advance)
            phase_q <= ~phase_q;
      end
   end

   assign phase_o = phase_q;
   assign valid_o = valid_q;

endmodule

// File: rtl/lptpg_split_reg.sv
module lptpg_split_reg #(
   parameter int unsigned          WIDTH   = 3,
   parameter logic [WIDTH-1:0]     TAPS    = 3'b110,
   parameter logic [WIDTH-1:0]     RST_VEC = 3'b001
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [WIDTH-1:0] seed_i,
   input  logic             step_a_i,
   input  logic             step_b_i,
   output logic [WIDTH-1:0] state_o
);

   localparam int unsigned LO = WIDTH / 2;
   localparam int unsigned HI = WIDTH - LO;
   localparam logic [WIDTH-1:0] NONZERO = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [LO-1:0]    lo_q;
   logic [HI-1:0]    hi_q;
   logic [HI-1:0]    pend_q;
   logic [WIDTH-1:0] cur;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] seed_fix;

   assign cur      = {hi_q, lo_q};
   assign nxt      = {cur[WIDTH-2:0], ^(cur & TAPS)};
   assign seed_fix = (seed_i == '0) ? NONZERO : seed_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lo_q   <= RST_VEC[LO-1:0];
         hi_q   <= RST_VEC[WIDTH-1:LO];
         pend_q <= '0;
      end else if (load_i) begin
         lo_q   <= seed_fix[LO-1:0];
         hi_q   <= seed_fix[WIDTH-1:LO];
      end else if (step_a_i) begin
         lo_q   <= nxt[LO-1:0];
         pend_q <= nxt[WIDTH-1:LO];
      end else if (step_b_i) begin
         hi_q   <= pend_q;
      end
   end

   assign state_o = cur;

endmodule

// File: rtl/lptpg_swap_net.sv
module lptpg_swap_net #(
   parameter int unsigned WIDTH = 3
) (
   input  logic [WIDTH-1:0] state_i,
   output logic [WIDTH-1:0] pattern_o
);

   localparam int unsigned LOWER = WIDTH - 1;
   localparam int unsigned NPAIR = LOWER / 2;

   logic sel;
   assign sel = state_i[WIDTH-1];
   assign pattern_o[WIDTH-1] = sel;

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      assign pattern_o[2*p]   = sel ? state_i[2*p+1] : state_i[2*p];
      assign pattern_o[2*p+1] = sel ? state_i[2*p]   : state_i[2*p+1];
   end

   if (LOWER % 2 == 1) begin : g_odd
      assign pattern_o[LOWER-1] = state_i[LOWER-1];
   end

endmodule

// File: rtl/lowpwr_tpg.sv
module lowpwr_tpg #(
   parameter int unsigned WIDTH    = 3,
   parameter int unsigned RST_SEED = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] seed_i,
   output logic [WIDTH-1:0] pattern_o,
   output logic             valid_o
);

   import lptpg_pkg::*;

   localparam logic [MAX_WIDTH-1:0] TAPS_FULL = tap_mask(WIDTH);
   localparam logic [WIDTH-1:0]     TAPS      = TAPS_FULL[WIDTH-1:0];
   localparam logic [WIDTH-1:0]     RST_VEC   = WIDTH'(RST_SEED);

   if (WIDTH < 2 || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("lowpwr_tpg: WIDTH out of range");
   end
   if (RST_VEC == '0) begin : g_bad_seed
      $error("lowpwr_tpg: RST_SEED must be nonzero");
   end

   logic             phase_q;
   logic             step_a;
   logic             step_b;
   logic [WIDTH-1:0] state_q;

   lptpg_phase u_phase (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .load_i   (load_i),
      .phase_o  (phase_q),
      .step_a_o (step_a),
      .step_b_o (step_b),
      .valid_o  (valid_o)
   );

   lptpg_split_reg #(
      .WIDTH   (WIDTH),
      .TAPS    (TAPS),
      .RST_VEC (RST_VEC)
   ) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .seed_i   (seed_i),
      .step_a_i (step_a),
      .step_b_i (step_b),
      .state_o  (state_q)
   );

   lptpg_swap_net #(
      .WIDTH (WIDTH)
   ) u_swap (
      .state_i   (state_q),
      .pattern_o (pattern_o)
   );

endmodule

// File: rtl/lowpwr_tpg_chk.sv
module lowpwr_tpg_chk #(
   parameter int unsigned WIDTH = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic             load_i,
   input logic [WIDTH-1:0] seed_i,
   input logic [WIDTH-1:0] pattern_o,
   input logic             valid_o,
   input logic [WIDTH-1:0] state_q,
   input logic             phase_q
);

   localparam int unsigned LO = WIDTH / 2;

   // R2: first half-step leaves upper bits alone
   a_r2_upper_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i && !phase_q) |=> (state_q[WIDTH-1:LO] == $past(state_q[WIDTH-1:LO])) && phase_q);

   // R3: second half-step leaves lower bits alone
   a_r3_lower_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i && phase_q) |=> (state_q[LO-1:0] == $past(state_q[LO-1:0])) && !phase_q);

   // R4: full states are nonzero
   a_r4_full_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !phase_q |-> (state_q != '0));

   // R5: strobe follows advance
   a_r5_valid_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !load_i) |=> valid_o);
   a_r5_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i || load_i) |=> !valid_o);

   // R6: idle hold
   a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i && !load_i) |=> $stable(pattern_o) && $stable(phase_q));

   // R7: load clears phase and takes the seed
   a_r7_load_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && seed_i != '0) |=> !phase_q && (state_q == $past(seed_i)));

   // R8: zero seed replaced
   a_r8_zero_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && seed_i == '0) |=> (state_q == {{(WIDTH-1){1'b0}}, 1'b1}));

   // R9: select bit reaches output unchanged
   a_r9_sel_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pattern_o[WIDTH-1] == state_q[WIDTH-1]);

endmodule

bind lowpwr_tpg lowpwr_tpg_chk #(.WIDTH(WIDTH)) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .en_i      (en_i),
   .load_i    (load_i),
   .seed_i    (seed_i),
   .pattern_o (pattern_o),
   .valid_o   (valid_o),
   .state_q   (state_q),
   .phase_q   (phase_q)
);

// File: tb/lowpwr_tpg_tb_top.sv
`timescale 1ns/1ps
module lowpwr_tpg_tb_top;

   localparam int unsigned W    = 3;
   localparam int unsigned LO   = W / 2;
   localparam int unsigned PER  = (1 << W) - 1;
   localparam logic [W-1:0] TAPS = 3'b110;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic         load = 1'b0;
   logic [W-1:0] seed = '0;
   logic [W-1:0] pattern;
   logic         valid;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lowpwr_tpg #(.WIDTH(W)) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .en_i      (en),
      .load_i    (load),
      .seed_i    (seed),
      .pattern_o (pattern),
      .valid_o   (valid)
   );

   // Reference model from the requirements
   logic [W-1:0] m_s = 3'b001;
   logic [W-1:0] m_pend = '0;
   bit           m_ph = 1'b0;
   logic [W-1:0] expq[$];

   bit           hd_on = 1'b0;
   int           hd_acc = 0;
   logic [W-1:0] hd_last = '0;

   function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
      return {s[W-2:0], ^(s & TAPS)};
   endfunction

   function automatic logic [W-1:0] swp(input logic [W-1:0] x);
      logic [W-1:0] y;
      y = x;
      if (x[W-1]) begin
         for (int p = 0; p < (W-1)/2; p++) begin
            y[2*p]   = x[2*p+1];
            y[2*p+1] = x[2*p];
         end
      end
      return y;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_half();
      logic [W-1:0] n;
      if (!m_ph) begin
         n = lfsr_next(m_s);
         m_pend = n[W-1:LO];
         m_s[LO-1:0] = n[LO-1:0];
      end else begin
         m_s[W-1:LO] = m_pend;
      end
      m_ph = ~m_ph;
      expq.push_back(swp(m_s));
   endtask

   task automatic run_steps(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         en = 1'b1;
         model_half();
      end
      @(negedge clk);
      en = 1'b0;
   endtask

   task automatic do_load(input logic [W-1:0] v);
      @(negedge clk);
      load = 1'b1;
      seed = v;
      @(negedge clk);
      load = 1'b0;
      m_s  = (v == '0) ? 3'b001 : v;
      m_ph = 1'b0;
   endtask

   // Monitor: scoreboard compare, R2/R3/R9 via model order, R5 via strobe
   always @(negedge clk) begin
      if (rst_n && valid) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R5 strobe without expected vector", 1, 0);
         end else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            chk(pattern == e, "R2/R3/R9 vector order", pattern, e);
         end
         if (hd_on) begin
            hd_acc += $countones(pattern ^ hd_last);
            hd_last = pattern;
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(pattern == 3'b001, "R1 reset pattern", pattern, 1);
      chk(valid == 1'b0, "R1 reset valid", valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pattern == 3'b001 && valid == 1'b0, "R1 after release", pattern, 1);

      // R2: first half-step, intermediate 000 expected from 001
      run_steps(1);
      chk(pattern == 3'b000, "R2 intermediate", pattern, 0);
      // R3: second half-step completes the Fibonacci step to 010
      run_steps(1);
      chk(pattern == 3'b010, "R3 full step", pattern, 2);

      // R6: idle hold
      begin
         logic [W-1:0] held;
         held = pattern;
         repeat (3) @(negedge clk);
         chk(pattern == held, "R6 idle pattern", pattern, held);
         chk(valid == 1'b0, "R5 idle strobe low", valid, 0);
      end

      // R9: state 101 shows swapped as 110
      run_steps(2);
      chk(pattern == 3'b110, "R9 swap when select set", pattern, 6);

      // R7: load mid-phase resets phase, then scoreboard
      run_steps(1);
      do_load(3'b101);
      chk(pattern == swp(3'b101), "R7 load value", pattern, swp(3'b101));
      chk(valid == 1'b0, "R5 strobe low after load", valid, 0);
      run_steps(5);

      // R7: load has priority over enable
      @(negedge clk);
      en = 1'b1;
      load = 1'b1;
      seed = 3'b110;
      @(negedge clk);
      en = 1'b0;
      load = 1'b0;
      m_s = 3'b110;
      m_ph = 1'b0;
      chk(pattern == swp(3'b110), "R7 load priority", pattern, swp(3'b110));
      chk(valid == 1'b0, "R7 no strobe on load", valid, 0);
      run_steps(3);

      // R8: zero seed replaced by 1
      do_load(3'b000);
      chk(pattern == 3'b001, "R8 zero seed", pattern, 1);

      // R4 and R10: period and distance over one full period
      begin
         logic [W-1:0] p0;
         logic [W-1:0] s;
         int plain;
         p0 = pattern;
         hd_last = pattern;
         hd_acc = 0;
         hd_on = 1'b1;
         for (int k = 1; k <= PER; k++) begin
            run_steps(2);
            if (k < PER)
               chk(pattern != p0, "R4 no early repeat", pattern, p0);
            else
               chk(pattern == p0, "R4 period end", pattern, p0);
         end
         hd_on = 1'b0;
         plain = 0;
         s = 3'b001;
         for (int k = 0; k < PER; k++) begin
            plain += $countones(s ^ lfsr_next(s));
            s = lfsr_next(s);
         end
         chk(hd_acc < 2 * plain, "R10 distance per vector", hd_acc, 2 * plain);
      end

      @(negedge clk);
      chk(expq.size() == 0, "R5 all expected vectors seen", expq.size(), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule